// File: doc/BRIEF.md
# Multi-mode fracturable logic element

This block is one programmable logic cell. It holds a 16-entry look-up table and two D flip-flops. A small configuration register chooses how the cell is used: as one 4-input function with a registered output, as two 3-input functions on the same three inputs with two registered outputs, or as a 2-bit shift register whose flip-flops are chained through dedicated wiring. Either output can bypass its flip-flop and present the combinational value instead.

The table word and the mode word are written through a one-word parallel port, with a select bit choosing which of the two is written. For test, asserting the test enable turns the two flip-flops into a scan chain. Data enters at the scan input, passes through the upper flip-flop, then the lower one, and leaves at the scan output. Every captured state can be shifted out this way whatever the mode.

Top module: `mm_logic_elem`

## Requirements
- R1: With `cfg_we` high at a clock edge, `cfg_sel`=0 loads `cfg_wdata` as the table word and `cfg_sel`=1 loads the mode word. In the mode word, bits [1:0] are the mode, bit 2 is the upper bypass and bit 3 is the lower bypass. The new setting governs behaviour from the next cycle on.
- R2: In mode 00, the upper flip-flop captures table bit `lut[in_i]`, where `in_i` is read as an unsigned index, and the lower flip-flop keeps its value.
- R3: In mode 01, the upper flip-flop captures `lut[8+in_i[2:0]]` and the lower flip-flop captures `lut[in_i[2:0]]`. `in_i[3]` has no effect. With table word 0xE896, the upper output is the carry and the lower output is the sum of a full adder on `in_i[2:0]`.
- R4: In mode 10, the upper flip-flop captures `shift_in` and the lower flip-flop captures the previous upper value.
- R5: While `test_en` is high, in any mode, the upper flip-flop captures `scan_in` and the lower flip-flop captures the previous upper value. `scan_out` always shows the lower flip-flop.
- R6: A synchronous active-high `rst` clears both flip-flops, the table word and the mode word, and it overrides `test_en`.
- R7: With a bypass bit set, the matching output shows the value its flip-flop would capture in normal operation in the current cycle. With the bypass bit clear, the output shows the flip-flop.
- R8: Mode 11 behaves exactly like mode 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the table word, 1 selects the mode word |
| cfg_wdata | input | 16 | Configuration write data |
| in_i | input | 4 | Table inputs |
| shift_in | input | 1 | Serial input used in shift-register mode |
| test_en | input | 1 | Scan enable |
| scan_in | input | 1 | Scan chain input |
| out_hi | output | 1 | Upper output |
| out_lo | output | 1 | Lower output |
| scan_out | output | 1 | Scan chain output |

## Verification
The bench builds the cell with its default 4-input table. At that size, every input combination can be swept in each mode. The dual-table mode is also checked against a full adder computed arithmetically, and in-mode sweeps use several table words. Reset is applied with test enable high, bypass is checked against the predicted next state, and scan data is traced through both flip-flops to `scan_out`.

// File: rtl/mm_logic_elem.sv
module mm_logic_elem #(
  parameter int LUT_IN = 4,
  localparam int LUT_BITS = 1 << LUT_IN
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic                cfg_sel,
  input  logic [LUT_BITS-1:0] cfg_wdata,
  input  logic [LUT_IN-1:0]   in_i,
  input  logic                shift_in,
  input  logic                test_en,
  input  logic                scan_in,
  output logic                out_hi,
  output logic                out_lo,
  output logic                scan_out
);
  localparam logic [1:0] M_DUAL  = 2'b01;
  localparam logic [1:0] M_SHIFT = 2'b10;

  logic [LUT_BITS-1:0] lut_q;
  logic [1:0]          mode_q;
  logic                byp_hi_q, byp_lo_q;
  logic                ff_hi, ff_lo;
  logic                d_hi, d_lo;
  logic [LUT_IN-2:0]   idx_lo;

  assign idx_lo = in_i[LUT_IN-2:0];

  always_comb begin
    case (mode_q)
      M_DUAL: begin
        d_hi = lut_q[{1'b1, idx_lo}];
        d_lo = lut_q[{1'b0, idx_lo}];
      end
      M_SHIFT: begin
        d_hi = shift_in;
        d_lo = ff_hi;
      end
      default: begin
        d_hi = lut_q[in_i];
        d_lo = ff_lo;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lut_q    <= '0;
      mode_q   <= 2'b00;
      byp_hi_q <= 1'b0;
      byp_lo_q <= 1'b0;
      ff_hi    <= 1'b0;
      ff_lo    <= 1'b0;
    end else begin
      if (cfg_we && !cfg_sel) lut_q <= cfg_wdata;
      if (cfg_we && cfg_sel) begin
        mode_q   <= cfg_wdata[1:0];
        byp_hi_q <= cfg_wdata[2];
        byp_lo_q <= cfg_wdata[3];
      end
      if (test_en) begin
        ff_hi <= scan_in;
        ff_lo <= ff_hi;
      end else begin
        ff_hi <= d_hi;
        ff_lo <= d_lo;
      end
    end
  end

  assign out_hi   = byp_hi_q ? d_hi : ff_hi;
  assign out_lo   = byp_lo_q ? d_lo : ff_lo;
  assign scan_out = ff_lo;

  // R6
  a_r6_reset_clears: assert property (@(posedge clk)
    rst |=> (!ff_hi && !ff_lo && lut_q == '0 && mode_q == 2'b00));

  // R5
  a_r5_scan_chain: assert property (@(posedge clk) disable iff (rst)
    test_en |=> (ff_hi == $past(scan_in) && scan_out == $past(ff_hi)));

  // R4
  a_r4_shift_pair: assert property (@(posedge clk) disable iff (rst)
    (!test_en && mode_q == M_SHIFT) |=> (ff_hi == $past(shift_in) && ff_lo == $past(ff_hi)));

  // R2, R8
  a_r2_lower_holds: assert property (@(posedge clk) disable iff (rst)
    (!test_en && (mode_q == 2'b00 || mode_q == 2'b11)) |=> $stable(ff_lo));

  // R7
  a_r7_registered_out: assert property (@(posedge clk) disable iff (rst)
    (!byp_hi_q && !test_en && !cfg_we) |=> (out_hi == $past(d_hi)));
endmodule

// File: tb/tb_mm_logic_elem.sv
module tb_mm_logic_elem;
  logic clk = 1'b0;
  logic rst, cfg_we, cfg_sel, shift_in, test_en, scan_in;
  logic [15:0] cfg_wdata;
  logic [3:0]  in_i;
  logic out_hi, out_lo, scan_out;

  int total = 0;
  int bad = 0;

  logic [15:0] mlut;
  logic [1:0]  mmode;
  logic mbh, mbl, mq_hi, mq_lo;

  always #5 clk = ~clk;

  mm_logic_elem dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .in_i(in_i), .shift_in(shift_in), .test_en(test_en), .scan_in(scan_in),
    .out_hi(out_hi), .out_lo(out_lo), .scan_out(scan_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [1:0] nxt(input logic [3:0] a, input logic sh);
    case (mmode)
      2'b01:   return {mlut[{1'b1, a[2:0]}], mlut[{1'b0, a[2:0]}]};
      2'b10:   return {sh, mq_hi};
      default: return {mlut[a], mq_lo};
    endcase
  endfunction

  task automatic cyc(input string req, input logic [3:0] a, input logic sh,
                     input logic te, input logic si,
                     input logic we = 1'b0, input logic sel = 1'b0,
                     input logic [15:0] wd = 16'h0);
    logic [1:0] d;
    in_i = a; shift_in = sh; test_en = te; scan_in = si;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    #1;
    d = nxt(a, sh);
    chk(req, out_hi, mbh ? d[1] : mq_hi);
    chk(req, out_lo, mbl ? d[0] : mq_lo);
    chk("R5", scan_out, mq_lo);
    @(posedge clk);
    if (te) begin
      mq_lo = mq_hi; mq_hi = si;
    end else begin
      mq_hi = d[1]; mq_lo = d[0];
    end
    if (we && !sel) mlut = wd;
    if (we && sel) begin
      mmode = wd[1:0]; mbh = wd[2]; mbl = wd[3];
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset(input logic te);
    rst = 1'b1; test_en = te; scan_in = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mlut = '0; mmode = 2'b00; mbh = 0; mbl = 0; mq_hi = 0; mq_lo = 0;
    chk("R6", out_hi, 1'b0);
    chk("R6", out_lo, 1'b0);
    chk("R6", scan_out, 1'b0);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; in_i = 0;
    shift_in = 0; test_en = 0; scan_in = 0;
    mlut = 0; mmode = 0; mbh = 0; mbl = 0; mq_hi = 0; mq_lo = 0;
    @(negedge clk);
    do_reset(1'b1);

    // R1 load table and mode words; R2 single 4-input sweep
    cyc("R1", 4'h0, 0, 0, 0, 1, 0, 16'h6A5C);
    cyc("R1", 4'h0, 0, 0, 0, 1, 1, 16'h0000);
    for (int a = 0; a < 16; a++) cyc("R2", 4'(a), a[0], 0, 0);
    cyc("R2", 4'h0, 0, 0, 0);
    cyc("R1", 4'h0, 0, 0, 0, 1, 0, 16'h8001);
    for (int a = 15; a >= 0; a--) cyc("R2", 4'(a), 0, 0, 0);
    cyc("R2", 4'h0, 0, 0, 0);

    // R8 reserved mode acts as single 4-input
    cyc("R8", 4'h0, 0, 0, 0, 1, 1, 16'h0003);
    cyc("R8", 4'h0, 0, 0, 0, 1, 0, 16'h3C96);
    for (int a = 0; a < 16; a++) cyc("R8", 4'(a), 1, 0, 0);
    cyc("R8", 4'h0, 0, 0, 0);

    // R3 dual 3-input as full adder, checked arithmetically
    cyc("R3", 4'h0, 0, 0, 0, 1, 0, 16'hE896);
    cyc("R3", 4'h0, 0, 0, 0, 1, 1, 16'h0001);
    for (int a = 0; a < 16; a++) begin
      int s;
      s = a[0] + a[1] + a[2];
      cyc("R3", 4'(a), 0, 0, 0);
      chk("R3 carry", out_hi, s[1]);
      chk("R3 sum", out_lo, s[0]);
    end

    // R7 bypass in dual mode
    cyc("R7", 4'h0, 0, 0, 0, 1, 1, 16'h000D);
    for (int a = 0; a < 16; a++) begin
      int s;
      s = a[0] + a[1] + a[2];
      in_i = 4'(a);
      #1;
      chk("R7 comb carry", out_hi, s[1]);
      chk("R7 comb sum", out_lo, s[0]);
      cyc("R7", 4'(a), 0, 0, 0);
    end
    cyc("R7", 4'h0, 0, 0, 0, 1, 1, 16'h0005);
    for (int a = 0; a < 8; a++) cyc("R7", 4'(a), 0, 0, 0);

    // R4 shift register
    cyc("R4", 4'h0, 0, 0, 0, 1, 1, 16'h0002);
    for (int k = 0; k < 12; k++) begin
      logic b;
      b = ((16'hB4E1 >> k) & 1) != 0;
      cyc("R4", 4'h5, b, 0, ~b);
    end
    cyc("R4", 4'h0, 0, 0, 0, 1, 1, 16'h0006);
    for (int k = 0; k < 8; k++) cyc("R4", 4'h0, k[1], 0, 0);

    // R5 scan chain in dual mode: scan_out lags scan_in by two cycles
    cyc("R5", 4'h0, 0, 0, 0, 1, 1, 16'h0001);
    for (int k = 0; k < 14; k++) begin
      logic b;
      b = ((16'h5B2D >> k) & 1) != 0;
      cyc("R5", 4'h7, 1, 1, b);
      if (k >= 1) chk("R5 lag", scan_out, ((16'h5B2D >> (k - 1)) & 1) != 0);
    end
    test_en = 0;

    // R6 reset overrides test enable and clears config
    cyc("R6", 4'h0, 0, 0, 0, 1, 0, 16'hFFFF);
    cyc("R6", 4'hF, 0, 0, 0, 1, 1, 16'h000C);
    do_reset(1'b1);
    for (int a = 0; a < 16; a++) cyc("R6", 4'(a), 1, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule